// File: doc/BRIEF.md
# Serial PHY Management Master

This block reads or writes one 16-bit register of an external PHY over a two-wire management link. One wire is a clock that the block makes, `mdc`. The other is a shared data line. The line appears at the block's ports as a driven value `mdio_o`, an enable `mdio_oe` and a sampled value `mdio_i`, so the tristate buffer sits outside the block. `mdc` is divided down from the system clock. Each half of an `mdc` period lasts `HALF_DIV` system clocks. The default of 20 keeps `mdc` at or below 2.5 MHz when the system clock is 100 MHz.

A transfer starts with a one-cycle `start` pulse while the block is idle. On that pulse the block latches the direction, the two 5-bit addresses and the write data. It then sends the following, in order:
- a 32-bit preamble;
- a start pattern, an opcode, the PHY address and the register address;
- a turnaround;
- 16 data bits;
- one trailing released cycle.

On a read, the PHY must pull the second turnaround bit low. If it does not, the block keeps clocking with the line released for 32 recovery cycles. It then finishes with the error flag set and the read data at zero.

Top module: `mdio_master`

## Requirements
- R1: Each transfer begins with 32 `mdc` rising edges. At each of them `mdio_oe` is 1 and the line is driven high.
- R2: The next 14 rising edges carry 0, 1, then the opcode, then `phy_addr` MSB first, then `reg_addr` MSB first, all with `mdio_oe` at 1. The opcode is 1,0 for a read (`rd_nwr`=1) and 0,1 for a write.
- R3: `mdio_o` and `mdio_oe` change only while `mdc` is low. The PHY's `mdio_i` is sampled at the system clock edge that raises `mdc`. Every `mdc` high or low phase inside a transfer lasts exactly `HALF_DIV` system clocks.
- R4: On a read, `mdio_oe` is 0 for both turnaround bits (rising edges 47 and 48). `mdio_i` at edge 48 must be 0. `mdio_i` at edges 49 to 64 forms `rd_data` from bit 15 down to bit 0.
- R5: If `mdio_i` is 1 at read edge 48, the block issues 32 more rising edges with `mdio_oe` at 0, for 80 edges in total. It then ends with `err`=1 and `rd_data`=0.
- R6: On a write, edges 47 and 48 carry 1 then 0, and edges 49 to 64 carry `wr_data` MSB first, all with `mdio_oe` at 1.
- R7: A transfer that is not in error has exactly 65 rising edges. The last one has `mdio_oe` at 0, and `mdc` is low after it.
- R8: A `start` pulse during a transfer is ignored. The frame in progress is unchanged, and no second transfer follows.
- R9: `done` is high for exactly one system clock per transfer, at the `mdc` fall that ends it. `rd_data` and `err` hold their values until the next accepted `start`. A start clears both, so a write leaves `rd_data` at 0 and `err` at 0.
- R10: In reset and when idle, `mdc`, `mdio_oe`, `done`, `err` and `rd_data` are 0. A reset in the middle of a transfer returns the block to that idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address inside the PHY |
| wr_data | input | 16 | Data to write |
| rd_data | output | 16 | Data read, or 0 after a write or an error |
| done | output | 1 | One-clock end-of-transfer pulse |
| err | output | 1 | Turnaround fault seen on the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Enable for driving the data line |
| mdio_i | input | 1 | Value sampled from the data line |

## Verification
The tests use writes and reads whose addresses and data are all ones, all zeros, alternating patterns, or have a single bit set at either end. These values show whether the shift order is right and whether the 5-bit address fields sit at the correct offsets. A read whose data is mostly zeros tells a PHY that really drives the line apart from the idle pull-up on the line. A read in which the PHY never drives the line sets off the turnaround fault. That test tells the recovery path apart from a normal read by counting the clock edges and checking that the data is zero. Further directed tests cover a start pulse during a transfer, a reset in the middle of a transfer, and the timing of each clock phase.

// File: rtl/mdio_pkg.sv
// mdio_pkg: frame lengths and the sequencer state type shared by the
// management master. Assumes clause-22 style framing only.
package mdio_pkg;
    localparam int PRE_LEN   = 32;  // preamble bits
    localparam int HDR_LEN   = 14;  // start(2) + opcode(2) + phy(5) + reg(5)
    localparam int DAT_LEN   = 16;  // data bits
    localparam int RECOV_LEN = 32;  // released cycles after a turnaround fault
    localparam int ADDR_W    = 5;
    localparam int CNT_W     = $clog2(PRE_LEN + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DAT,
        ST_TAIL,
        ST_RECOV
    } mdio_st_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// mdio_mdc_gen: makes the management clock from the system clock.
// While run is high, mdc toggles every HALF_DIV system clocks, starting
// low. rise_ev / fall_ev flag the system clock edge that raises or lowers
// mdc. Assumes HALF_DIV >= 2.
module mdio_mdc_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          tick;

    // end of the current half period
    assign tick    = run && (cnt_q == CW'(HALF_DIV - 1));
    assign rise_ev = tick && !mdc;
    assign fall_ev = tick && mdc;

    // half-period counter and clock flop; idle holds mdc low
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rx_shift.sv
// mdio_rx_shift: MSB-first capture register for read data. Cleared when a
// transfer is accepted. Shifts in din on each enable.
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    // clear at start, shift left on each sampled bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (en)       q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/mdio_seq.sv
// mdio_seq: frame sequencer. It accepts a start while idle and walks the
// phases preamble, header, turnaround, data and tail, or recovery after a
// turnaround fault. It drives the line on each mdc fall and samples it on
// each mdc rise. Assumes rise_ev and fall_ev come from mdio_mdc_gen.
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DAT_LEN-1:0] wr_data,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rx_clr,
    output logic              rx_en,
    output logic              done,
    output logic              err
);
    mdio_st_t            st_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                rd_q;
    logic                ta_bad_q;
    logic [HDR_LEN-1:0]  hdr_q;
    logic [DAT_LEN-1:0]  wsh_q;
    logic                start_acc;

    // a start counts only while idle
    assign start_acc = start && (st_q == ST_IDLE);
    assign busy      = (st_q != ST_IDLE);
    assign rx_clr    = start_acc;
    assign rx_en     = rise_ev && (st_q == ST_DAT) && rd_q;

    // phase sequencing, line drive and turnaround check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            rd_q     <= 1'b0;
            ta_bad_q <= 1'b0;
            hdr_q    <= '0;
            wsh_q    <= '0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    st_q     <= ST_PRE;
                    cnt_q    <= '0;
                    rd_q     <= rd_nwr;
                    ta_bad_q <= 1'b0;
                    hdr_q    <= {2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr};
                    wsh_q    <= wr_data;
                    mdio_o   <= 1'b1;
                    mdio_oe  <= 1'b1;
                    err      <= 1'b0;
                end
                ST_PRE: if (fall_ev) begin
                    if (cnt_q == CNT_W'(PRE_LEN - 1)) begin
                        st_q   <= ST_HDR;
                        cnt_q  <= '0;
                        mdio_o <= hdr_q[HDR_LEN-1];
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HDR: if (fall_ev) begin
                    if (cnt_q == CNT_W'(HDR_LEN - 1)) begin
                        st_q  <= ST_TA;
                        cnt_q <= '0;
                        if (rd_q) mdio_oe <= 1'b0;
                        else      mdio_o  <= 1'b1;
                    end else begin
                        cnt_q  <= cnt_q + 1'b1;
                        hdr_q  <= hdr_q << 1;
                        mdio_o <= hdr_q[HDR_LEN-2];
                    end
                end
                ST_TA: begin
                    if (rise_ev && rd_q && (cnt_q == CNT_W'(1)))
                        ta_bad_q <= mdio_i;
                    if (fall_ev) begin
                        if (cnt_q == '0) begin
                            cnt_q <= CNT_W'(1);
                            if (!rd_q) mdio_o <= 1'b0;
                        end else begin
                            cnt_q <= '0;
                            if (rd_q && ta_bad_q) begin
                                st_q <= ST_RECOV;
                            end else begin
                                st_q <= ST_DAT;
                                if (!rd_q) mdio_o <= wsh_q[DAT_LEN-1];
                            end
                        end
                    end
                end
                ST_DAT: if (fall_ev) begin
                    if (cnt_q == CNT_W'(DAT_LEN - 1)) begin
                        st_q    <= ST_TAIL;
                        cnt_q   <= '0;
                        mdio_o  <= 1'b0;
                        mdio_oe <= 1'b0;
                    end else begin
                        cnt_q  <= cnt_q + 1'b1;
                        wsh_q  <= wsh_q << 1;
                        mdio_o <= wsh_q[DAT_LEN-2];
                    end
                end
                ST_TAIL: if (fall_ev) begin
                    st_q <= ST_IDLE;
                    done <= 1'b1;
                end
                ST_RECOV: if (fall_ev) begin
                    if (cnt_q == CNT_W'(RECOV_LEN - 1)) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                        done  <= 1'b1;
                        err   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // done never lasts two clocks
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // err only moves on an accepted start or at the end of a transfer
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start) |=> $stable(err));
    // the line is released during the read turnaround
    assert_ta_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TA && rd_q) |-> !mdio_oe);
    // the line is not driven while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !mdio_oe);
    // a start during a transfer does not relatch the direction
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(rd_q));
endmodule

// File: rtl/mdio_master.sv
// mdio_master: management master for one 16-bit PHY register per transfer.
// It joins the clock divider, the frame sequencer and the read capture
// register. Assumes an external tristate buffer and a pull-up on the line.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        done,
    output logic        err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic busy, rise_ev, fall_ev, rx_clr, rx_en;

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc_gen (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    mdio_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
        .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rx_clr(rx_clr), .rx_en(rx_en), .done(done), .err(err)
    );

    mdio_rx_shift #(.W(DAT_LEN)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .en(rx_en),
        .din(mdio_i), .q(rd_data)
    );

    // line outputs hold while mdc stays high
    assert_line_low_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // no clock outside a transfer
    assert_idle_mdc_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
endmodule

// File: tb/mdio_master_bench.sv
// mdio_master_bench: a vector table walked by one loop, then directed tests
// for a start while busy and a reset in the middle of a transfer. A
// behavioural PHY answers reads, and every mdc rise is recorded.
module mdio_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int NVEC       = 6;
    // {rd_nwr, fault, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 5'h01, 5'h00, 16'h1234},
        {1'b1, 1'b0, 5'h1F, 5'h1F, 16'hA5C3},
        {1'b0, 1'b0, 5'h10, 5'h0A, 16'hFFFF},
        {1'b1, 1'b0, 5'h00, 5'h01, 16'h0001},
        {1'b1, 1'b1, 5'h05, 5'h02, 16'hBEEF},
        {1'b0, 1'b0, 5'h15, 5'h15, 16'h8001}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_nwr = 1'b0;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic done, err, mdc, mdio_o, mdio_oe, mdio_i;

    int tests = 0, fails = 0, cyc = 0;
    int k_rise = 0, done_cnt = 0, hp_bad = 0, lc_bad = 0, hp_cnt = 0;
    bit hp_valid = 0;
    logic mdc_d = 1'b0, o_d = 1'b0, oe_d = 1'b0;
    logic cur_rd = 1'b0, cur_fault = 1'b0;
    logic [15:0] cur_data = '0;
    logic phy_drv = 1'b0, phy_val = 1'b1;
    logic rec_bit [1:100];
    logic rec_oe  [1:100];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .err(err), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // shared line with pull-up
    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    // record each rise and let the PHY answer reads
    always @(posedge mdc) begin
        k_rise = k_rise + 1;
        if (k_rise <= 100) begin
            rec_bit[k_rise] = mdio_i;
            rec_oe[k_rise]  = mdio_oe;
        end
        if (cur_rd) begin
            if (k_rise == 47) begin
                phy_drv = !cur_fault;
                phy_val = 1'b0;
            end else if (k_rise >= 48 && k_rise <= 63) begin
                phy_val = cur_data[63 - k_rise];
            end else if (k_rise == 64) begin
                phy_drv = 1'b0;
            end
        end
    end

    // phase length and change-while-high monitor, sampled off the edge
    always @(negedge clk) begin
        if (!rst_n) begin
            hp_valid = 0;
            hp_cnt   = 0;
        end else begin
            hp_cnt = hp_cnt + 1;
            if (mdc !== mdc_d) begin
                if (hp_valid && hp_cnt != HALF) hp_bad = hp_bad + 1;
                hp_valid = 1;
                hp_cnt   = 0;
            end
            if (mdc && mdc_d && (mdio_o !== o_d || mdio_oe !== oe_d)) lc_bad = lc_bad + 1;
            if (done) begin
                done_cnt = done_cnt + 1;
                hp_valid = 0;
            end
        end
        mdc_d = mdc;
        o_d   = mdio_o;
        oe_d  = mdio_oe;
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // global watchdog
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // count recorded bits that differ from the frame the requirements give
    function automatic int frame_errs(input logic rd, input logic fault,
                                      input logic [4:0] pa, input logic [4:0] ra,
                                      input logic [15:0] d);
        logic [13:0] hdr;
        int n, last;
        logic eoe, ebit;
        hdr  = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
        last = (rd && fault) ? 80 : 65;
        n = 0;
        for (int k = 1; k <= last; k++) begin
            eoe  = 1'b1;
            ebit = 1'b1;
            if (k >= 33 && k <= 46)      ebit = hdr[13 - (k - 33)];
            else if (k >= 47 && rd)      eoe  = 1'b0;
            else if (k == 47)            ebit = 1'b1;
            else if (k == 48)            ebit = 1'b0;
            else if (k >= 49 && k <= 64) ebit = d[64 - k];
            else if (k == 65)            eoe  = 1'b0;
            if (rec_oe[k] !== eoe || (eoe && rec_bit[k] !== ebit)) n++;
        end
        return n;
    endfunction

    // run one transfer; poke fires a second start part way through
    task automatic run_txn(input logic [27:0] v, input bit poke);
        logic rd, fault;
        logic [4:0] pa, ra;
        logic [15:0] d, rd_at_done;
        logic err_at_done;
        bit seen;
        {rd, fault, pa, ra, d} = v;
        cur_rd = rd; cur_fault = fault; cur_data = d;
        phy_drv = 1'b0; k_rise = 0; done_cnt = 0;
        @(negedge clk);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (poke && i == 100) begin
                rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~d; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) seen = 1;
            else @(negedge clk);
        end
        start = 1'b0;
        chk("R9 done seen (watchdog)", {31'd0, seen}, 32'd1);
        rd_at_done  = rd_data;
        err_at_done = err;
        repeat (8 * HALF) @(negedge clk);
        if (rd && fault) begin
            chk("R5 frame and recovery", frame_errs(rd, fault, pa, ra, d), 0);
            chk("R5 rise count", k_rise, 80);
            chk("R5 err set", {31'd0, err_at_done}, 32'd1);
            chk("R5 rd_data zero", {16'd0, rd_at_done}, 32'd0);
        end else if (rd) begin
            chk("R1 R2 R4 read frame", frame_errs(rd, fault, pa, ra, d), 0);
            chk("R7 rise count", k_rise, 65);
            chk("R4 rd_data", {16'd0, rd_at_done}, {16'd0, d});
            chk("R4 err clear", {31'd0, err_at_done}, 32'd0);
        end else begin
            chk("R1 R2 R6 write frame", frame_errs(rd, fault, pa, ra, d), 0);
            chk("R7 rise count", k_rise, 65);
            chk("R9 rd_data zero after write", {16'd0, rd_at_done}, 32'd0);
            chk("R9 err clear after write", {31'd0, err_at_done}, 32'd0);
        end
        chk("R9 done one clock", done_cnt, 1);
        chk("R9 hold rd_data", {16'd0, rd_data}, {16'd0, rd_at_done});
        chk("R9 hold err", {31'd0, err}, {31'd0, err_at_done});
        chk("R7 mdc low after", {31'd0, mdc}, 32'd0);
    endtask

    initial begin
        // reset state
        repeat (5) @(negedge clk);
        chk("R10 reset mdc", {31'd0, mdc}, 32'd0);
        chk("R10 reset oe", {31'd0, mdio_oe}, 32'd0);
        chk("R10 reset done/err", {30'd0, done, err}, 32'd0);
        chk("R10 reset rd_data", {16'd0, rd_data}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk
        for (int i = 0; i < NVEC; i++) run_txn(VEC[i], 1'b0);

        // start while busy is ignored
        run_txn({1'b0, 1'b0, 5'h0C, 5'h13, 16'h5A5A}, 1'b1);
        chk("R8 no follow-on transfer", k_rise, 65);

        // reset in the middle of a read
        cur_rd = 1'b1; cur_fault = 1'b0; cur_data = 16'hFFFF; k_rise = 0;
        @(negedge clk);
        rd_nwr = 1'b1; phy_addr = 5'h02; reg_addr = 5'h03; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        phy_drv = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 mid reset mdc/oe", {30'd0, mdc, mdio_oe}, 32'd0);
        chk("R10 mid reset rd_data", {16'd0, rd_data}, 32'd0);
        rst_n = 1'b1;
        k_rise = 0;
        repeat (50) @(negedge clk);
        chk("R10 idle after reset", k_rise, 0);
        run_txn({1'b1, 1'b0, 5'h0A, 5'h05, 16'h8000}, 1'b0);

        chk("R3 half period length", hp_bad, 0);
        chk("R3 line steady while mdc high", lc_bad, 0);
        summary();
        $finish;
    end
endmodule